// File: doc/BRIEF.md
# Horizontal 8-Tap Reuse Convolver

This block filters an image one row at a time with a fixed horizontal 8-tap kernel. Samples arrive on a valid-qualified stream, and the first sample of every row is marked with a start-of-row flag. Each row carries `ROW_OUTS + 8` samples. Output `c` of the row is the weighted sum of samples `c` through `c+7`. The tap weights are 1, 0, 1, 2, 2, 1, 0, 1 for taps 0 to 7. The result leaves on a second stream qualified by its own valid.

Each sample is read from the stream exactly once. It is stored in an 8-slot circular window and reused by up to eight outputs. At the start of a row, the first seven samples fill slots 0 to 6 and produce no output. From then on, every new sample is written into slot `index mod 8` and completes one output. Tap `dc` of output `c` reads slot `(c+dc) mod 8`.

A controller with four states sequences the row:
- `ST_IDLE` waits for a start-of-row sample.
- `ST_LOAD` takes the preload samples.
- `ST_RUN` emits one output per sample.
- `ST_TAIL` accepts and drops the final sample of the row.

The transitions are:
- restart: any state to `ST_LOAD`, on an accepted start-of-row sample.
- preload-done: `ST_LOAD` to `ST_RUN`, on sample index 6.
- row-done: `ST_RUN` to `ST_TAIL`, on sample index `ROW_OUTS+6`.
- tail-drop: `ST_TAIL` to `ST_IDLE`.

Top module: `hconv8_reuse`

## Requirements
- R1: After reset, `out_valid` is low and samples are ignored until a sample arrives with `in_sor` high.
- R2: Output `c` equals `s[c] + s[c+2] + 2*s[c+3] + 2*s[c+4] + s[c+5] + s[c+7]`, where `s[k]` is sample `k` of the row (the one with `in_sor` high is `k=0`). `out_data` is 11 bits unsigned, so all-255 input gives 2040.
- R3: Samples 0 to 6 of a row produce no output.
- R4: `out_valid` is high for one cycle, in the cycle right after the clock edge that accepts sample `c+7` (for `c` from 0 to `ROW_OUTS-1`). It is never high otherwise.
- R5: Each row gives exactly `ROW_OUTS` outputs. Sample `ROW_OUTS+7` is accepted and dropped with no output.
- R6: A sample with `in_sor` high restarts the row at any point. It becomes sample 0, and the partial row produces no further outputs.
- R7: Cycles with `in_valid` low have no effect, whatever `in_sor` and `in_data` hold.
- R8: After a row has completed, samples without `in_sor` are ignored until the next start-of-row sample.
- R9: A new row may start in the cycle right after the last sample of the previous row, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sor | input | 1 | Marks the first sample of a row (read only when `in_valid` is high) |
| in_data | input | DATA_W | Unsigned input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | DATA_W+3 | Filtered output |

## Verification
A wrong slot pointer or a corrupted window slot changes `out_data` on the first output that reads the bad slot. That output appears at most eight accepted samples later and is caught by the direct-sum comparison. A state register that advances at the wrong sample index moves the `out_valid` pulses by whole samples, which is seen in the first row. A restart that fails to clear leaves extra or missing pulses, which is seen within the next row.

// File: rtl/hconv_pkg.sv
package hconv_pkg;

    localparam int TAPS   = 8;
    localparam int SLOT_W = $clog2(TAPS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_TAIL = 2'd3
    } row_state_e;

    // Fixed kernel weight of each tap position.
    function automatic int tap_weight(input int t);
        case (t)
            0: return 1;
            1: return 0;
            2: return 1;
            3: return 2;
            4: return 2;
            5: return 1;
            6: return 0;
            7: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/hconv_row_ctrl.sv
module hconv_row_ctrl
    import hconv_pkg::*;
#(
    parameter int ROW_OUTS = 16,
    localparam int IDX_W = $clog2(ROW_OUTS + TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sor,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] base_slot,
    output logic              emit,
    output row_state_e        state_o
);

    localparam logic [IDX_W-1:0] LOAD_LAST = IDX_W'(TAPS - 2);
    localparam logic [IDX_W-1:0] RUN_LAST  = IDX_W'(ROW_OUTS + TAPS - 2);

    row_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (in_valid) begin
            if (in_sor) begin
                state_d = ST_LOAD;
                idx_d   = IDX_W'(1);
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_LOAD: begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == LOAD_LAST) state_d = ST_RUN;
                    end
                    ST_RUN: begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == RUN_LAST) state_d = ST_TAIL;
                    end
                    ST_TAIL: begin
                        idx_d   = '0;
                        state_d = ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        wr_slot   = in_sor ? '0 : idx_q[SLOT_W-1:0];
        base_slot = wr_slot + 1'b1;
        wr_en     = 1'b0;
        emit      = 1'b0;
        if (in_valid) begin
            if (in_sor) begin
                wr_en = 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_LOAD: wr_en = 1'b1;
                    ST_RUN: begin
                        wr_en = 1'b1;
                        emit  = 1'b1;
                    end
                    ST_TAIL: ;
                    default: ;
                endcase
            end
        end
    end

    assign state_o = state_q;

    // R6
    sor_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sor) |=> (state_q == ST_LOAD && idx_q == IDX_W'(1)));

    // R5
    tail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && in_valid && !in_sor) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/hconv_win_buf.sv
module hconv_win_buf
    import hconv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [TAPS*DATA_W-1:0]   view
);

    logic [DATA_W-1:0] mem [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_slot] <= wr_data;
        end
    end

    // Window as seen by the current cycle: the slot being written shows the
    // incoming sample so the output completes in the same cycle.
    for (genvar s = 0; s < TAPS; s++) begin : g_view
        assign view[s*DATA_W +: DATA_W] =
            (wr_en && wr_slot == SLOT_W'(s)) ? wr_data : mem[s];
    end

    // R2
    slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_slot)] == $past(wr_data)));

endmodule

// File: rtl/hconv_tap_sum.sv
module hconv_tap_sum
    import hconv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 11
) (
    input  logic [TAPS*DATA_W-1:0] view,
    input  logic [SLOT_W-1:0]      base_slot,
    output logic [ACC_W-1:0]       sum
);

    logic [ACC_W-1:0] term [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam int WT = tap_weight(g);
        if (WT == 0) begin : g_zero
            assign term[g] = '0;
        end else begin : g_live
            logic [SLOT_W-1:0] slot;
            logic [DATA_W-1:0] smp;
            assign slot = base_slot + SLOT_W'(g);
            assign smp  = view[slot*DATA_W +: DATA_W];
            if (WT == 2) begin : g_dbl
                assign term[g] = ACC_W'(smp) << 1;
            end else begin : g_one
                assign term[g] = ACC_W'(smp);
            end
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < TAPS; i++) sum = sum + term[i];
    end

endmodule

// File: rtl/hconv8_reuse.sv
module hconv8_reuse
    import hconv_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ROW_OUTS = 16,
    localparam int ACC_W   = DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sor,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);

    localparam int CNT_W = $clog2(ROW_OUTS + 2);

    logic                   wr_en, emit;
    logic [SLOT_W-1:0]      wr_slot, base_slot;
    logic [TAPS*DATA_W-1:0] view;
    logic [ACC_W-1:0]       sum;
    row_state_e             state;

    hconv_row_ctrl #(.ROW_OUTS(ROW_OUTS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sor    (in_sor),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .base_slot (base_slot),
        .emit      (emit),
        .state_o   (state)
    );

    hconv_win_buf #(.DATA_W(DATA_W)) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (in_data),
        .view    (view)
    );

    hconv_tap_sum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) sum_i (
        .view      (view),
        .base_slot (base_slot),
        .sum       (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_data <= sum;
        end
    end

    // Checker-only count of outputs issued since the last row start.
    logic [CNT_W-1:0] emit_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 emit_cnt_q <= '0;
        else if (in_valid && in_sor) emit_cnt_q <= '0;
        else if (emit)              emit_cnt_q <= emit_cnt_q + 1'b1;
    end

    // R5
    row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_cnt_q <= CNT_W'(ROW_OUTS));

    // R4
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R3
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> !out_valid);

endmodule

// File: tb/hconv8_reuse_tb_top.sv
module hconv8_reuse_tb_top;

    localparam int W      = 16;
    localparam int ROW_N  = W + 8;
    localparam int MAXN   = 64;
    localparam int COEF [8] = '{1, 0, 1, 2, 2, 1, 0, 1};
    // {seed[23:16], step[15:8], gap_mode[7:0]}
    localparam logic [23:0] PAT [6] = '{
        24'h03_05_00, 24'h10_1D_01, 24'hF0_07_02,
        24'h7F_33_00, 24'h01_FF_01, 24'hA5_0B_02
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sor = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [10:0] out_data;

    hconv8_reuse #(.DATA_W(8), .ROW_OUTS(W)) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sor (in_sor),
        .in_data (in_data), .out_valid (out_valid), .out_data (out_data)
    );

    always #5 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    logic [10:0] exp_mem [0:4095];
    int          wr = 0;
    int          rd = 0;
    logic        exp_ov = 1'b0;
    string       ov_tag = "R1";
    string       val_tag = "R2";
    logic [7:0]  row_buf [0:MAXN-1];

    // Output monitor, sampled after the outputs settle.
    always @(posedge clk) begin
        #2;
        checks++;
        if (out_valid !== exp_ov) begin
            errors++;
            $display("FAIL %s out_valid actual=%b expected=%b", ov_tag, out_valid, exp_ov);
        end
        if (out_valid === 1'b1) begin
            checks++;
            if (rd == wr) begin
                errors++;
                $display("FAIL R5 extra output actual=%0d expected=none", out_data);
            end else begin
                if (out_data !== exp_mem[rd]) begin
                    errors++;
                    $display("FAIL %s out_data actual=%0d expected=%0d", val_tag, out_data, exp_mem[rd]);
                end
                rd++;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sor = 1'b0; exp_ov = 1'b0; ov_tag = "R4";
        end
    endtask

    // fill: 0 pattern, 1 all 255, 2 all zero
    task automatic drive_row(input int seed, input int step, input int gap_mode,
                             input int n, input bit use_sor, input int fill);
        for (int k = 0; k < n; k++) begin
            if (fill == 1)      row_buf[k] = 8'hFF;
            else if (fill == 2) row_buf[k] = 8'h00;
            else                row_buf[k] = 8'((seed + k*step + ((k*k) >> 1)) & 255);
        end
        if (use_sor) begin
            for (int c = 0; c < W && c + 7 < n; c++) begin
                int s = 0;
                for (int dc = 0; dc < 8; dc++) s += COEF[dc] * int'(row_buf[c+dc]);
                exp_mem[wr] = 11'(s);
                wr++;
            end
        end
        for (int k = 0; k < n; k++) begin
            int g = (gap_mode != 0 && k % 3 == 1) ? gap_mode : 0;
            repeat (g) begin
                @(negedge clk);
                in_valid = 1'b0; in_sor = 1'b1; in_data = 8'h5A;
                exp_ov = 1'b0; ov_tag = "R7";
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sor   = use_sor && k == 0;
            in_data  = row_buf[k];
            exp_ov   = use_sor && k >= 7 && k <= W + 6;
            if (!use_sor || k > W + 7) ov_tag = "R8";
            else if (k < 7)            ov_tag = "R3";
            else if (k == W + 7)       ov_tag = "R5";
            else                       ov_tag = "R4";
        end
    endtask

    task automatic drained(input string tag);
        checks++;
        if (rd != wr) begin
            errors++;
            $display("FAIL %s outputs missing actual=%0d expected=%0d", tag, rd, wr);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        idle(2);

        // R1: samples before any row start are ignored
        drive_row(9, 3, 0, 12, 1'b0, 0);
        idle(2);
        drained("R1");

        // Table of row patterns (R2, R4, R7)
        for (int p = 0; p < 6; p++) begin
            val_tag = "R2";
            drive_row(int'(PAT[p][23:16]), int'(PAT[p][15:8]), int'(PAT[p][7:0]), ROW_N, 1'b1, 0);
            idle(3);
            drained("R5");
        end

        // R2 extremes
        drive_row(0, 0, 0, ROW_N, 1'b1, 1);
        idle(2);
        drive_row(0, 0, 1, ROW_N, 1'b1, 2);
        idle(2);
        drained("R2");

        // R6: abort a row after 10 samples, then restart
        val_tag = "R6";
        drive_row(40, 13, 0, 10, 1'b1, 0);
        drive_row(77, 21, 0, ROW_N, 1'b1, 0);
        idle(3);
        drained("R6");

        // R9: back-to-back rows without idle
        val_tag = "R9";
        drive_row(5, 17, 0, ROW_N, 1'b1, 0);
        drive_row(200, 9, 0, ROW_N, 1'b1, 0);
        drive_row(33, 41, 2, ROW_N, 1'b1, 0);
        idle(3);
        drained("R9");

        // R8: extra samples after the row end are ignored
        val_tag = "R8";
        drive_row(61, 5, 0, ROW_N + 6, 1'b1, 0);
        idle(3);
        drained("R8");

        // R1: reset mid-preload, then unflagged samples, then a clean row
        val_tag = "R1";
        drive_row(90, 4, 0, 5, 1'b1, 0);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0; exp_ov = 1'b0; ov_tag = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        drive_row(18, 6, 0, 10, 1'b0, 0);
        drive_row(120, 3, 1, ROW_N, 1'b1, 0);
        idle(3);
        drained("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule